// File: doc/BRIEF.md
# NAND Sector Hamming ECC Engine

This block protects one main-area sector of a NAND page with a single-error-correcting, double-error-detecting Hamming code. Sector bytes stream through it between the page buffer and the flash, each one tagged with its byte index. In program mode it folds the main bytes into a running code and then emits the finished code, which the surrounding logic writes into the spare slot. In read mode it also takes in the spare slot, picks out the stored code, and compares it with the recomputed one. It then classifies the mismatch.

A single flipped data bit is repaired in the buffer without software. The block issues a write-back strobe that carries the byte index and a one-hot mask of the bit to invert. A hit on one bit of the stored code is reported as repaired and needs no data change. Every other mismatch is reported as uncorrectable. The result is held in a 4-bit status word until the next accepted sector start. All of this runs only while the enable input is high.

The code has 2·(log2(SECTOR_BYTES)+3) bits: 24 bits for the default 512-byte sector.

Top module: `nand_sector_ecc`

## Requirements
- R1: Program mode. The accepted byte at index SECTOR_BYTES-1 completes the sector. Two clock edges after that byte is sampled, `code_vld` is high for exactly one cycle and `code_out` holds the code.
  - The code is built from bit pairs. Pair p covers bit p of the position value {byte index, bit number 0..7}: pairs 0-2 cover the bit number and pairs 3 and up cover the byte index.
  - Bit 2p is the XOR of all data bits whose position has bit p set. Bit 2p+1 is the XOR of all data bits whose position has bit p clear.
  - Code byte k is `code_out[8k+7:8k]`.
- R2: Read mode.
  - Indices SECTOR_BYTES and above address the spare slot at offset index-SECTOR_BYTES.
  - The stored code byte k is taken from spare offset 6+k. All other spare bytes have no effect on the result.
  - The byte at the last spare offset (SPARE_BYTES-1) completes the sector.
  - Read mode never raises `code_vld`.
- R3: In read mode, when the recomputed and stored codes match, `ecc_status` becomes 0 and `fix_we` stays low.
- R4: When the syndrome differs in exactly one bit of every pair, `fix_we` pulses once in the same cycle that `ecc_status` changes.
  - `fix_idx` carries the byte index taken from pairs 3 and up.
  - `fix_mask` has only bit b set, where b is taken from pairs 0-2.
  - `ecc_status` becomes 4'b0100.
- R5: A syndrome with exactly one differing bit gives `ecc_status` = 4'b0001 and no write-back.
- R6: Any other nonzero syndrome gives `ecc_status` = 4'b1000 and no write-back.
- R7: `ecc_status` layout and lifetime.
  - Bits [1:0] hold the spare-region code and bits [3:2] hold the main-region code: 0 = clean, 1 = repaired, 2 = uncorrectable.
  - The value is 0 after reset.
  - It changes only when a read sector completes or when a sector start is accepted. A start clears it to 0 on the next edge.
- R8: While `ecc_en` is low, sector starts and bytes are ignored. No code is emitted, no write-back occurs and the status is unchanged.
- R9: A sector start and a byte accepted in the same cycle make that byte the first byte of the new sector.
- R10: When a sector start falls in the cycle after a read sector's last byte:
  - `ecc_status` and the write-back show the finished sector's result.
  - The new sector still accumulates from an empty code.
- R11: Main bytes other than the completing index may arrive in any order, and the code depends only on the (index, value) pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Enables generation and checking |
| sec_start | input | 1 | Start-of-sector strobe |
| sec_read | input | 1 | Mode sampled with the start: 1 read/check, 0 program/generate |
| byte_vld | input | 1 | Stream byte valid |
| byte_idx | input | 10 | Byte index: main below SECTOR_BYTES, spare above |
| byte_data | input | 8 | Stream byte |
| code_vld | output | 1 | One-cycle pulse, generated code valid |
| code_out | output | 24 | Generated code |
| fix_we | output | 1 | Buffer write-back strobe (invert masked bit) |
| fix_idx | output | 9 | Byte index of the write-back |
| fix_mask | output | 8 | One-hot bit to invert |
| ecc_status | output | 4 | {main result, spare result} |

## Verification
The completion of a read sector and the acceptance of the next sector start can land on the same clock edge. In that case, the status update and the status clear compete for one register, and the code accumulator is read by the decoder while it is being cleared. The bench provokes this by raising the start in the cycle right after the last spare byte of a read sector that carries a single-bit error. It judges the result in two ways:
- The status and write-back must carry the finished sector's repair.
- A following program sector, sent without a further start, must produce the code computed only from its own bytes.

A start that shares a cycle with the first byte is exercised the same way, by comparing the emitted code against the full-sector expectation.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  // per-region result codes
  localparam logic [1:0] RES_NONE  = 2'd0;
  localparam logic [1:0] RES_FIXED = 2'd1;
  localparam logic [1:0] RES_FATAL = 2'd2;

  typedef enum logic [1:0] {
    SYN_CLEAN = 2'd0,
    SYN_DATA1 = 2'd1,
    SYN_CODE1 = 2'd2,
    SYN_MULTI = 2'd3
  } syn_cls_e;

  // status word = {main result, spare result}
  function automatic logic [3:0] status_of(input syn_cls_e c);
    logic [3:0] s;
    case (c)
      SYN_DATA1: s = {RES_FIXED, RES_NONE};
      SYN_CODE1: s = {RES_NONE,  RES_FIXED};
      SYN_MULTI: s = {RES_FATAL, RES_NONE};
      default:   s = {RES_NONE,  RES_NONE};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sec_ecc_accum.sv
module sec_ecc_accum #(
  parameter int IDX_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      fold,
  input  logic [IDX_W-1:0]          idx,
  input  logic [7:0]                data,
  output logic [2*(IDX_W+3)-1:0]    acc
);
  localparam int PAIRS  = IDX_W + 3;
  localparam int CODE_W = 2 * PAIRS;

  // contribution of one byte: column pairs from bit number, line pairs from index
  function automatic logic [CODE_W-1:0] byte_contrib(input logic [IDX_W-1:0] i,
                                                      input logic [7:0] d);
    logic [CODE_W-1:0] r;
    logic [7:0]        hi;
    logic              row;
    r   = '0;
    row = ^d;
    for (int c = 0; c < 3; c++) begin
      for (int b = 0; b < 8; b++) hi[b] = ((b >> c) & 1) == 1;
      r[2*c]   = ^(d & hi);
      r[2*c+1] = ^(d & ~hi);
    end
    for (int k = 0; k < IDX_W; k++) begin
      r[2*(k+3)]   = row & i[k];
      r[2*(k+3)+1] = row & ~i[k];
    end
    return r;
  endfunction

  logic [CODE_W-1:0] contrib;
  assign contrib = fold ? byte_contrib(idx, data) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= contrib;
    else          acc <= acc ^ contrib;
  end

endmodule

// File: rtl/sec_ecc_syndrome.sv
module sec_ecc_syndrome
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic [2*(IDX_W+3)-1:0] calc,
  input  logic [2*(IDX_W+3)-1:0] stored,
  output syn_cls_e               cls,
  output logic [IDX_W-1:0]       err_idx,
  output logic [7:0]             err_mask
);
  localparam int PAIRS  = IDX_W + 3;
  localparam int CODE_W = 2 * PAIRS;
  localparam int CNT_W  = $clog2(CODE_W + 1);

  function automatic logic [CNT_W-1:0] pop(input logic [CODE_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int j = 0; j < CODE_W; j++) n = n + CNT_W'(v[j]);
    return n;
  endfunction

  logic [CODE_W-1:0] syn;
  logic [PAIRS-1:0]  pos;
  logic [PAIRS-1:0]  split;
  logic [CNT_W-1:0]  ones;

  assign syn = calc ^ stored;

  generate
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign pos[p]   = syn[2*p];
      assign split[p] = syn[2*p] ^ syn[2*p+1];
    end
  endgenerate

  assign ones = pop(syn);

  always_comb begin
    if (syn == '0)            cls = SYN_CLEAN;
    else if (ones == CNT_W'(1)) cls = SYN_CODE1;
    else if (&split)          cls = SYN_DATA1;
    else                      cls = SYN_MULTI;
  end

  assign err_idx  = pos[PAIRS-1:3];
  assign err_mask = 8'b1 << pos[2:0];

endmodule

// File: rtl/nand_sector_ecc.sv
module nand_sector_ecc
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SPARE_BYTES  = 16,
  parameter int CODE_OFS     = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ecc_en,
  input  logic                                  sec_start,
  input  logic                                  sec_read,
  input  logic                                  byte_vld,
  input  logic [$clog2(SECTOR_BYTES):0]         byte_idx,
  input  logic [7:0]                            byte_data,
  output logic                                  code_vld,
  output logic [2*($clog2(SECTOR_BYTES)+3)-1:0] code_out,
  output logic                                  fix_we,
  output logic [$clog2(SECTOR_BYTES)-1:0]       fix_idx,
  output logic [7:0]                            fix_mask,
  output logic [3:0]                            ecc_status
);
  localparam int IDX_W      = $clog2(SECTOR_BYTES);
  localparam int PAIRS      = IDX_W + 3;
  localparam int CODE_W     = 2 * PAIRS;
  localparam int CODE_BYTES = (CODE_W + 7) / 8;
  localparam logic [IDX_W:0] LAST_MAIN  = (IDX_W+1)'(SECTOR_BYTES - 1);
  localparam logic [IDX_W:0] LAST_SPARE = (IDX_W+1)'(SECTOR_BYTES + SPARE_BYTES - 1);

  // ---- accept / mode ----
  logic start_ok, byte_ok, in_main, cur_rd, last_byte;
  logic rd_q, done_q, done_rd_q;
  logic prog_done, read_done;

  assign start_ok  = ecc_en & sec_start;
  assign byte_ok   = ecc_en & byte_vld;
  assign in_main   = ~byte_idx[IDX_W];
  assign cur_rd    = start_ok ? sec_read : rd_q;
  assign last_byte = byte_ok & (cur_rd ? (byte_idx == LAST_SPARE) : (byte_idx == LAST_MAIN));
  assign prog_done = done_q & ~done_rd_q;
  assign read_done = done_q & done_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      done_q    <= 1'b0;
      done_rd_q <= 1'b0;
    end else begin
      if (start_ok) rd_q <= sec_read;
      done_q    <= last_byte;
      done_rd_q <= cur_rd;
    end
  end

  // ---- code accumulation over main bytes ----
  logic [CODE_W-1:0] calc_code;

  sec_ecc_accum #(.IDX_W(IDX_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ok),
    .fold  (byte_ok & in_main),
    .idx   (byte_idx[IDX_W-1:0]),
    .data  (byte_data),
    .acc   (calc_code)
  );

  // ---- stored code capture from the spare slot ----
  logic [CODE_BYTES-1:0]   code_hit;
  logic [8*CODE_BYTES-1:0] stored_q;
  logic [CODE_W-1:0]       stored_code;

  generate
    for (genvar k = 0; k < CODE_BYTES; k++) begin : g_hit
      assign code_hit[k] = byte_ok & ~in_main &
                           (byte_idx[IDX_W-1:0] == IDX_W'(CODE_OFS + k));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stored_q <= '0;
    else begin
      if (start_ok) stored_q <= '0;
      for (int k = 0; k < CODE_BYTES; k++)
        if (code_hit[k]) stored_q[8*k +: 8] <= byte_data;
    end
  end

  assign stored_code = stored_q[CODE_W-1:0];

  // ---- syndrome classification ----
  syn_cls_e          syn_cls;
  logic [IDX_W-1:0]  err_idx;
  logic [7:0]        err_mask;

  sec_ecc_syndrome #(.IDX_W(IDX_W)) u_syn (
    .calc     (calc_code),
    .stored   (stored_code),
    .cls      (syn_cls),
    .err_idx  (err_idx),
    .err_mask (err_mask)
  );

  // ---- completion outputs; completion outranks the start clear ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_vld   <= 1'b0;
      code_out   <= '0;
      fix_we     <= 1'b0;
      fix_idx    <= '0;
      fix_mask   <= '0;
      ecc_status <= '0;
    end else begin
      code_vld <= prog_done;
      fix_we   <= read_done & (syn_cls == SYN_DATA1);
      if (prog_done) code_out <= calc_code;
      if (read_done) begin
        fix_idx    <= err_idx;
        fix_mask   <= err_mask;
        ecc_status <= status_of(syn_cls);
      end else if (start_ok) begin
        ecc_status <= '0;
      end
    end
  end

  // ---- assertions ----
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecc_en && !done_q) |=> (!code_vld && !fix_we));

  a_r4_fix_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> ($countones(fix_mask) == 1 && ecc_status == 4'b0100));

  a_r1_code_not_with_fix: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |-> !fix_we);

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && !done_q) |=> (ecc_status == 4'b0000));

  a_r7_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_ok && !done_q) |=> $stable(ecc_status));

  a_r6_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_status[3:2] != 2'b11 && ecc_status[1] == 1'b0));

  a_r5_code_hit_no_fix: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && syn_cls == SYN_CODE1) |=> (!fix_we && ecc_status == 4'b0001));

  a_r4_decode_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_cls == SYN_DATA1) |-> ($countones(err_mask) == 1));

endmodule

// File: tb/tb_nand_sector_ecc.sv
module tb_nand_sector_ecc;
  localparam int SEC = 32;
  localparam int SPR = 16;
  localparam int OFS = 6;
  localparam int CW  = 16;

  logic        clk = 1'b0;
  logic        rst_n, ecc_en, sec_start, sec_read, byte_vld;
  logic [5:0]  byte_idx;
  logic [7:0]  byte_data;
  logic        code_vld, fix_we;
  logic [CW-1:0] code_out;
  logic [4:0]  fix_idx;
  logic [7:0]  fix_mask;
  logic [3:0]  ecc_status;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mem [SEC];
  logic [7:0] spr [SPR];

  always #4 clk = ~clk;

  nand_sector_ecc #(.SECTOR_BYTES(SEC), .SPARE_BYTES(SPR), .CODE_OFS(OFS)) dut (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .sec_start(sec_start),
    .sec_read(sec_read), .byte_vld(byte_vld), .byte_idx(byte_idx),
    .byte_data(byte_data), .code_vld(code_vld), .code_out(code_out),
    .fix_we(fix_we), .fix_idx(fix_idx), .fix_mask(fix_mask),
    .ecc_status(ecc_status)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected code: each set bit toggles one bit of every pair, chosen by its position
  function automatic logic [CW-1:0] ref_code();
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < SEC; i++)
      for (int b = 0; b < 8; b++)
        if (mem[i][b]) begin
          logic [7:0] pos;
          pos = {i[4:0], b[2:0]};
          for (int p = 0; p < 8; p++)
            if (pos[p]) c[2*p] = ~c[2*p];
            else        c[2*p+1] = ~c[2*p+1];
        end
    return c;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < SEC; i++) mem[i] = 8'((i * 37 + seed * 59 + i * i * seed) ^ (i << 2));
  endtask

  task automatic put_code(input logic [CW-1:0] c);
    for (int k = 0; k < SPR; k++) spr[k] = 8'(8'hC3 ^ (k * 17));
    spr[OFS]   = c[7:0];
    spr[OFS+1] = c[15:8];
  endtask

  // smode: 0 separate start, 1 start with first byte, 2 no start
  task automatic stream(input bit rd, input bit rev, input int smode);
    if (smode == 0) begin
      sec_start = 1'b1; sec_read = rd;
      @(negedge clk);
      sec_start = 1'b0;
    end
    for (int n = 0; n < SEC; n++) begin
      int i;
      i = (rev && n < SEC - 1) ? SEC - 2 - n : n;
      byte_vld = 1'b1; byte_idx = 6'(i); byte_data = mem[i];
      if (smode == 1 && n == 0) begin sec_start = 1'b1; sec_read = rd; end
      @(negedge clk);
      sec_start = 1'b0;
    end
    if (rd)
      for (int k = 0; k < SPR; k++) begin
        byte_vld = 1'b1; byte_idx = 6'(SEC + k); byte_data = spr[k];
        @(negedge clk);
      end
    byte_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [CW-1:0] c, exp;
    rst_n = 1'b0; ecc_en = 1'b0; sec_start = 1'b0; sec_read = 1'b0;
    byte_vld = 1'b0; byte_idx = '0; byte_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; ecc_en = 1'b1;
    @(negedge clk);
    check(!code_vld && !fix_we && ecc_status == 4'h0, "R7 reset state",
          {code_vld, fix_we, ecc_status}, 0);

    // R1 / R9 / R11: program mode under several patterns
    for (int pat = 0; pat < 6; pat++) begin
      if (pat == 0)      for (int i = 0; i < SEC; i++) mem[i] = 8'h00;
      else if (pat == 1) for (int i = 0; i < SEC; i++) mem[i] = 8'hFF;
      else fill(pat);
      exp = ref_code();
      stream(1'b0, pat == 3, pat == 4 ? 1 : 0);
      @(negedge clk);
      check(code_vld && code_out == exp && !fix_we,
            pat == 3 ? "R11 out-of-order code" : (pat == 4 ? "R9 start with first byte" : "R1 program code"),
            {code_vld, code_out}, {1'b1, exp});
      @(negedge clk);
      check(!code_vld, "R1 code_vld single pulse", code_vld, 0);
    end

    // R3 / R2: clean reads, spare filler varied
    fill(7); c = ref_code(); put_code(c);
    stream(1'b1, 1'b0, 0);
    @(negedge clk);
    check(ecc_status == 4'h0 && !fix_we && !code_vld, "R3 clean read",
          {code_vld, fix_we, ecc_status}, 0);
    for (int k = 0; k < SPR; k++) if (k != OFS && k != OFS + 1) spr[k] = 8'hFF;
    stream(1'b1, 1'b0, 0);
    @(negedge clk);
    check(ecc_status == 4'h0 && !fix_we, "R2 non-code spare bytes ignored",
          {fix_we, ecc_status}, 0);

    // R4: every single data bit
    fill(9); c = ref_code();
    for (int i = 0; i < SEC; i++)
      for (int b = 0; b < 8; b++) begin
        put_code(c);
        mem[i] ^= 8'(1 << b);
        stream(1'b1, 1'b0, 0);
        @(negedge clk);
        check(fix_we && fix_idx == 5'(i) && fix_mask == 8'(1 << b) && ecc_status == 4'h4,
              "R4 single data bit repair",
              {fix_we, fix_idx, fix_mask, ecc_status}, {1'b1, 5'(i), 8'(1 << b), 4'h4});
        mem[i] ^= 8'(1 << b);
      end

    // R5: every single code bit
    for (int j = 0; j < CW; j++) begin
      put_code(c ^ CW'(1 << j));
      stream(1'b1, 1'b0, 0);
      @(negedge clk);
      check(!fix_we && ecc_status == 4'h1, "R5 code bit hit",
            {fix_we, ecc_status}, 4'h1);
    end

    // R6: double data errors and data+code combination
    for (int t = 0; t < 16; t++) begin
      int i1, b1, i2, b2;
      i1 = (t * 5) % SEC; b1 = t % 8; i2 = (t * 11 + 3) % SEC; b2 = (t * 3 + 1) % 8;
      if (i1 == i2 && b1 == b2) b2 = b2 ^ 1;
      put_code(c);
      mem[i1] ^= 8'(1 << b1); mem[i2] ^= 8'(1 << b2);
      stream(1'b1, 1'b0, 0);
      @(negedge clk);
      check(!fix_we && ecc_status == 4'h8, "R6 double error",
            {fix_we, ecc_status}, 4'h8);
      mem[i1] ^= 8'(1 << b1); mem[i2] ^= 8'(1 << b2);
    end
    put_code(c ^ CW'(1 << 5));
    mem[17] ^= 8'h08;
    stream(1'b1, 1'b0, 0);
    @(negedge clk);
    check(!fix_we && ecc_status == 4'h8, "R6 data plus code error",
          {fix_we, ecc_status}, 4'h8);
    mem[17] ^= 8'h08;

    // R7 hold
    repeat (5) @(negedge clk);
    check(ecc_status == 4'h8, "R7 status held while idle", ecc_status, 4'h8);

    // R8: disabled
    ecc_en = 1'b0;
    fill(3);
    stream(1'b0, 1'b0, 0);
    @(negedge clk);
    check(!code_vld && ecc_status == 4'h8, "R8 program ignored when disabled",
          {code_vld, ecc_status}, 4'h8);
    put_code(ref_code()); mem[2] ^= 8'h01;
    stream(1'b1, 1'b0, 0);
    @(negedge clk);
    check(!fix_we && ecc_status == 4'h8, "R8 read ignored when disabled",
          {fix_we, ecc_status}, 4'h8);
    ecc_en = 1'b1;

    // R7 clear on start
    sec_start = 1'b1; sec_read = 1'b0;
    @(negedge clk);
    sec_start = 1'b0;
    check(ecc_status == 4'h0, "R7 start clears status", ecc_status, 0);

    // R10: start in the completion cycle
    fill(12); put_code(ref_code()); mem[3] ^= 8'h20;
    stream(1'b1, 1'b0, 0);
    sec_start = 1'b1; sec_read = 1'b0;
    @(negedge clk);
    sec_start = 1'b0;
    check(fix_we && fix_idx == 5'd3 && fix_mask == 8'h20 && ecc_status == 4'h4,
          "R10 completion wins over start",
          {fix_we, fix_idx, fix_mask, ecc_status}, {1'b1, 5'd3, 8'h20, 4'h4});
    fill(13); exp = ref_code();
    stream(1'b0, 1'b0, 2);
    @(negedge clk);
    check(code_vld && code_out == exp, "R10 new sector accumulates fresh",
          {code_vld, code_out}, {1'b1, exp});
    check(ecc_status == 4'h4, "R7 program completion leaves status", ecc_status, 4'h4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule